// File: doc/BRIEF.md
# SD Host Completion Interrupt Status

This block holds the two completion flags at the bottom of an SD host controller's normal interrupt status word. The flags are transfer done and command done. It watches the controller's internal status strobes and levels, and latches a sticky flag when a completion event occurs. Software acknowledges a flag by writing a one to its bit position through a plain register write port.

Transfer done is raised by the falling edge of an activity level, and the transfer direction picks which level:

- For a read, it is the read-transfer-active level.
- For a write, it is the DAT-line-active level, which drops only after the last data has gone to the card and busy has been released.

A transfer that parks at a block gap after a stop request produces the same falling edge, so it is covered without extra logic. Command done is raised by the response end-bit strobe, unless that response belongs to an automatically issued stop command.

Two decoded status codes sit beside the flags:

- One combines transfer done with the data-timeout flag.
- One combines command done with the command-timeout flag.

In both codes, the transfer completion and the command timeout win their respective tie. A level interrupt output reports any flag whose enable bit is set.

Top module: `sdh_irq_status`

## Requirements
- R1: While reset is asserted and right after it, `stat_o` is 2'b00 and `irq_o` is 0.
- R2: With `xfer_is_read`=1, a 1-to-0 change of `rd_xfer_busy` sets `stat_o[1]` (transfer done) on that clock edge. The same change with `xfer_is_read`=0 leaves the bit unchanged.
- R3: With `xfer_is_read`=0, a 1-to-0 change of `dat_busy` sets `stat_o[1]`. The same change with `xfer_is_read`=1 leaves the bit unchanged. A rising edge, or a level held low, never sets it.
- R4: `rsp_end_stb`=1 with `rsp_is_auto_stop`=0 sets `stat_o[0]` (command done) on that clock edge.
- R5: `rsp_end_stb`=1 with `rsp_is_auto_stop`=1 leaves `stat_o[0]` unchanged.
- R6: A cycle with `wr_en`=1 clears each status bit whose position in `wr_data` holds 1, where bit 1 is transfer done and bit 0 is command done. Positions holding 0, and cycles with `wr_en`=0, change nothing.
- R7: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends at 1.
- R8: `xfer_code_o` is 2 (done) when `stat_o[1]`=1, whatever `data_tmo` is. It is 1 (timed out during transfer) when `stat_o[1]`=0 and `data_tmo`=1. It is 0 (interrupted by another cause) when both are 0.
- R9: `cmd_code_o` is 2 (response bad) whenever `cmd_tmo`=1, whatever `stat_o[0]` is. It is 1 (response good) when `stat_o[0]`=1 and `cmd_tmo`=0. It is 0 otherwise.
- R10: With `IRQ_REG`=0, `irq_o` equals the OR over both bits of `stat_o & irq_en`, in the same cycle.
- R11: A set bit holds at 1 through any number of cycles without a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_is_read | input | 1 | Transfer direction, 1 = read from card |
| rd_xfer_busy | input | 1 | Read transfer active level |
| dat_busy | input | 1 | DAT line active level |
| rsp_end_stb | input | 1 | One-cycle strobe on command response end bit |
| rsp_is_auto_stop | input | 1 | Current response belongs to an automatic stop command |
| data_tmo | input | 1 | Data timeout flag |
| cmd_tmo | input | 1 | Command timeout flag |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | WR_W | Write data, ones clear the matching status bits |
| irq_en | input | 2 | Per-bit interrupt enables |
| stat_o | output | 2 | Status bits {transfer done, command done} |
| xfer_code_o | output | 2 | Decoded transfer outcome |
| cmd_code_o | output | 2 | Decoded command outcome |
| irq_o | output | 1 | Level interrupt |

## Verification
The edge properties use `$fell` on the activity inputs, while the design compares each input against a flop that reset clears. The two agree only if the activity levels are low while reset is held. The bench therefore drives every input to 0 before and during reset. After that it changes inputs only at falling clock edges, so every level is stable across the edge that samples it. The command properties also take `rsp_end_stb` as a single-cycle pulse, and every sweep in the bench keeps it that way.

// File: rtl/sdh_irq_pkg.sv
`timescale 1ns/1ps
package sdh_irq_pkg;
   // bit positions software decodes in the status word
   localparam int unsigned CMD_POS  = 0;
   localparam int unsigned XFER_POS = 1;
   localparam int unsigned N_STAT   = 2;

   typedef enum logic [1:0] {
      XF_OTHER = 2'd0,
      XF_TMO   = 2'd1,
      XF_DONE  = 2'd2
   } xfer_code_e;

   typedef enum logic [1:0] {
      CM_NONE = 2'd0,
      CM_OK   = 2'd1,
      CM_BAD  = 2'd2
   } cmd_code_e;
endpackage

// File: rtl/sdh_fall_det.sv
`timescale 1ns/1ps
module sdh_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/sdh_w1c_bit.sv
`timescale 1ns/1ps
module sdh_w1c_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;   // hardware event beats software clear
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/sdh_stat_decode.sv
`timescale 1ns/1ps
module sdh_stat_decode
   import sdh_irq_pkg::*;
(
   input  logic       xfer_done,
   input  logic       data_tmo,
   input  logic       cmd_done,
   input  logic       cmd_tmo,
   output xfer_code_e xfer_code,
   output cmd_code_e  cmd_code
);
   always_comb begin
      if (xfer_done)     xfer_code = XF_DONE;
      else if (data_tmo) xfer_code = XF_TMO;
      else               xfer_code = XF_OTHER;
   end

   always_comb begin
      if (cmd_tmo)       cmd_code = CM_BAD;
      else if (cmd_done) cmd_code = CM_OK;
      else               cmd_code = CM_NONE;
   end
endmodule

// File: rtl/sdh_irq_status.sv
`timescale 1ns/1ps
module sdh_irq_status
   import sdh_irq_pkg::*;
#(
   parameter int unsigned WR_W    = 16,
   parameter bit          IRQ_REG = 1'b0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            xfer_is_read,
   input  logic            rd_xfer_busy,
   input  logic            dat_busy,
   input  logic            rsp_end_stb,
   input  logic            rsp_is_auto_stop,
   input  logic            data_tmo,
   input  logic            cmd_tmo,
   input  logic            wr_en,
   input  logic [WR_W-1:0] wr_data,
   input  logic [1:0]      irq_en,
   output logic [1:0]      stat_o,
   output logic [1:0]      xfer_code_o,
   output logic [1:0]      cmd_code_o,
   output logic            irq_o
);
   localparam int unsigned N_ACT  = 2;
   localparam int unsigned ACT_RD = 0;
   localparam int unsigned ACT_WR = 1;

   if (WR_W < N_STAT) begin : g_bad_width
      $error("sdh_irq_status: WR_W must cover the status bits");
   end

   // falling edge of each activity level
   logic [N_ACT-1:0] act_lvl;
   logic [N_ACT-1:0] act_fall;
   assign act_lvl[ACT_RD] = rd_xfer_busy;
   assign act_lvl[ACT_WR] = dat_busy;

   for (genvar i = 0; i < N_ACT; i++) begin : g_edge
      sdh_fall_det u_fd (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (act_lvl[i]),
         .fall (act_fall[i])
      );
   end

   // set and clear requests per status bit
   logic [N_STAT-1:0] set_vec;
   logic [N_STAT-1:0] clr_vec;
   logic [N_STAT-1:0] stat_q;

   assign set_vec[XFER_POS] = xfer_is_read ? act_fall[ACT_RD] : act_fall[ACT_WR];
   assign set_vec[CMD_POS]  = rsp_end_stb & ~rsp_is_auto_stop;
   assign clr_vec           = {N_STAT{wr_en}} & wr_data[N_STAT-1:0];

   if (WR_W > N_STAT) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^wr_data[WR_W-1:N_STAT];
   end

   for (genvar b = 0; b < N_STAT; b++) begin : g_bit
      sdh_w1c_bit u_bit (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (set_vec[b]),
         .clr  (clr_vec[b]),
         .q    (stat_q[b])
      );
   end

   assign stat_o = stat_q;

   xfer_code_e xf_code;
   cmd_code_e  cm_code;

   sdh_stat_decode u_dec (
      .xfer_done(stat_q[XFER_POS]),
      .data_tmo (data_tmo),
      .cmd_done (stat_q[CMD_POS]),
      .cmd_tmo  (cmd_tmo),
      .xfer_code(xf_code),
      .cmd_code (cm_code)
   );

   assign xfer_code_o = xf_code;
   assign cmd_code_o  = cm_code;

   // interrupt output: combinational or flopped variant
   logic irq_raw;
   assign irq_raw = |(stat_q & irq_en);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end
endmodule

// File: rtl/sdh_irq_status_chk.sv
`timescale 1ns/1ps
module sdh_irq_status_chk #(
   parameter int unsigned WR_W    = 16,
   parameter bit          IRQ_REG = 1'b0
)(
   input logic            clk,
   input logic            rst_n,
   input logic            xfer_is_read,
   input logic            rd_xfer_busy,
   input logic            dat_busy,
   input logic            rsp_end_stb,
   input logic            rsp_is_auto_stop,
   input logic            data_tmo,
   input logic            cmd_tmo,
   input logic            wr_en,
   input logic [WR_W-1:0] wr_data,
   input logic [1:0]      irq_en,
   input logic [1:0]      stat_o,
   input logic [1:0]      xfer_code_o,
   input logic [1:0]      cmd_code_o,
   input logic            irq_o
);
   a_r1_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (stat_o == 2'b00));

   a_r2_read_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_is_read && $fell(rd_xfer_busy)) |=> stat_o[1]);

   a_r3_write_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_is_read && $fell(dat_busy)) |=> stat_o[1]);

   // R4 and R7: a non-auto response end always leaves command done set
   a_r4_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_end_stb && !rsp_is_auto_stop) |=> stat_o[0]);

   a_r5_auto_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[0]) |-> $past(rsp_end_stb && !rsp_is_auto_stop));

   a_r6_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && !(rsp_end_stb && !rsp_is_auto_stop)) |=> !stat_o[0]);

   a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[0] && !(wr_en && wr_data[0])) |=> stat_o[0]);

   a_r8_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[1] |-> (xfer_code_o == 2'd2));

   a_r9_tmo_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_tmo |-> (cmd_code_o == 2'd2));

   if (IRQ_REG) begin : g_irq_ff_chk
      a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == $past(|(stat_o & irq_en)));
   end else begin : g_irq_comb_chk
      a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == |(stat_o & irq_en));
   end
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.WR_W(WR_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .xfer_is_read    (xfer_is_read),
   .rd_xfer_busy    (rd_xfer_busy),
   .dat_busy        (dat_busy),
   .rsp_end_stb     (rsp_end_stb),
   .rsp_is_auto_stop(rsp_is_auto_stop),
   .data_tmo        (data_tmo),
   .cmd_tmo         (cmd_tmo),
   .wr_en           (wr_en),
   .wr_data         (wr_data),
   .irq_en          (irq_en),
   .stat_o          (stat_o),
   .xfer_code_o     (xfer_code_o),
   .cmd_code_o      (cmd_code_o),
   .irq_o           (irq_o)
);

// File: tb/sim_sdh_irq_status.sv
`timescale 1ns/1ps
module sim_sdh_irq_status;
   localparam int WR_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            xfer_is_read = 1'b0;
   logic            rd_xfer_busy = 1'b0;
   logic            dat_busy = 1'b0;
   logic            rsp_end_stb = 1'b0;
   logic            rsp_is_auto_stop = 1'b0;
   logic            data_tmo = 1'b0;
   logic            cmd_tmo = 1'b0;
   logic            wr_en = 1'b0;
   logic [WR_W-1:0] wr_data = '0;
   logic [1:0]      irq_en = 2'b00;
   logic [1:0]      stat_o;
   logic [1:0]      xfer_code_o;
   logic [1:0]      cmd_code_o;
   logic            irq_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   sdh_irq_status #(.WR_W(WR_W), .IRQ_REG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .xfer_is_read(xfer_is_read),
      .rd_xfer_busy(rd_xfer_busy), .dat_busy(dat_busy),
      .rsp_end_stb(rsp_end_stb), .rsp_is_auto_stop(rsp_is_auto_stop),
      .data_tmo(data_tmo), .cmd_tmo(cmd_tmo), .wr_en(wr_en),
      .wr_data(wr_data), .irq_en(irq_en), .stat_o(stat_o),
      .xfer_code_o(xfer_code_o), .cmd_code_o(cmd_code_o), .irq_o(irq_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock edge, returning to the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_all();
      wr_en = 1'b1; wr_data = 16'h0003;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   // bring the status bits to v using write-direction transfers and strobes
   task automatic set_stat(input logic [1:0] v);
      clear_all();
      xfer_is_read = 1'b0;
      if (v[1]) begin
         dat_busy = 1'b1;
         step();
      end
      dat_busy = 1'b0;
      rsp_end_stb = v[0];
      rsp_is_auto_stop = 1'b0;
      step();
      rsp_end_stb = 1'b0;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(stat_o == 2'b00 && irq_o == 1'b0, "R1 reset", int'(stat_o), 0);
      rst_n = 1'b1;
      step();
      chk(stat_o == 2'b00, "R1 after reset", int'(stat_o), 0);

      // R2/R3: direction x activity signal sweep
      for (int dir = 0; dir < 2; dir++) begin
         for (int sig = 0; sig < 2; sig++) begin
            clear_all();
            xfer_is_read = dir[0];
            if (sig == 0) rd_xfer_busy = 1'b1; else dat_busy = 1'b1;
            step();
            chk(stat_o[1] == 1'b0, "R3 rising edge no set", int'(stat_o[1]), 0);
            step();
            chk(stat_o[1] == 1'b0, "R3 high level no set", int'(stat_o[1]), 0);
            rd_xfer_busy = 1'b0; dat_busy = 1'b0;
            step();
            begin
               logic exp_b;
               exp_b = (dir == 1 && sig == 0) || (dir == 0 && sig == 1);
               chk(stat_o[1] == exp_b, (sig == 0) ? "R2 read fall" : "R3 write fall",
                   int'(stat_o[1]), int'(exp_b));
            end
            repeat (3) step();
            chk(stat_o[1] == ((dir == 1 && sig == 0) || (dir == 0 && sig == 1)),
                "R11 hold / R3 low level no set", int'(stat_o[1]), -1);
         end
      end

      // R4/R5: response strobe with and without automatic stop flag
      for (int au = 0; au < 2; au++) begin
         clear_all();
         rsp_end_stb = 1'b1; rsp_is_auto_stop = au[0];
         step();
         rsp_end_stb = 1'b0; rsp_is_auto_stop = 1'b0;
         chk(stat_o[0] == !au[0], (au == 0) ? "R4 cmd done" : "R5 auto stop ignored",
             int'(stat_o[0]), int'(!au[0]));
         step();
         chk(stat_o[0] == !au[0], "R11 cmd hold", int'(stat_o[0]), int'(!au[0]));
      end

      // R6: write-one-clear sweep over start state, data, enable
      for (int init = 0; init < 4; init++) begin
         for (int wd = 0; wd < 4; wd++) begin
            for (int en = 0; en < 2; en++) begin
               logic [1:0] exp_s;
               set_stat(init[1:0]);
               chk(stat_o == init[1:0], "R6 setup", int'(stat_o), init);
               wr_en = en[0]; wr_data = {14'h3FFC, wd[1:0]};
               step();
               wr_en = 1'b0; wr_data = '0;
               exp_s = en[0] ? (init[1:0] & ~wd[1:0]) : init[1:0];
               chk(stat_o == exp_s, "R6 w1c", int'(stat_o), int'(exp_s));
            end
         end
      end

      // R7: set and clear in the same cycle, both bits
      clear_all();
      xfer_is_read = 1'b0;
      dat_busy = 1'b1;
      step();
      dat_busy = 1'b0; rsp_end_stb = 1'b1;
      wr_en = 1'b1; wr_data = 16'h0003;
      step();
      wr_en = 1'b0; wr_data = '0; rsp_end_stb = 1'b0;
      chk(stat_o == 2'b11, "R7 set wins", int'(stat_o), 3);

      // R8/R9: decode sweep
      for (int s = 0; s < 4; s++) begin
         set_stat(s[1:0]);
         for (int f = 0; f < 4; f++) begin
            int exp_x;
            int exp_c;
            data_tmo = f[0]; cmd_tmo = f[1];
            #1;
            exp_x = s[1] ? 2 : (f[0] ? 1 : 0);
            exp_c = f[1] ? 2 : (s[0] ? 1 : 0);
            chk(int'(xfer_code_o) == exp_x, "R8 xfer decode", int'(xfer_code_o), exp_x);
            chk(int'(cmd_code_o) == exp_c, "R9 cmd decode", int'(cmd_code_o), exp_c);
         end
         data_tmo = 1'b0; cmd_tmo = 1'b0;
      end

      // R10: interrupt level sweep
      for (int s = 0; s < 4; s++) begin
         set_stat(s[1:0]);
         for (int e = 0; e < 4; e++) begin
            logic exp_i;
            irq_en = e[1:0];
            #1;
            exp_i = |(s[1:0] & e[1:0]);
            chk(irq_o == exp_i, "R10 irq", int'(irq_o), int'(exp_i));
         end
         irq_en = 2'b00;
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule